// File: doc/BRIEF.md
# XGMII Transmit MAC with Inline CRC-32

This block turns frames from a 64-bit streaming source into XGMII transmit characters. The source presents eight bytes per beat with valid, ready, start-of-packet, end-of-packet and an empty-byte count on the last beat. Each beat is one XGMII word. For every frame the block inserts a start word that carries the preamble and the start-of-frame delimiter. It passes the payload through unchanged and computes a CRC-32 over the payload bytes as they go by. It appends the four CRC bytes straight after the last payload byte and closes the frame with a terminate character. Every lane that carries nothing holds the idle character.

The path is transparent: it changes no payload byte, and it adds neither padding nor a minimum gap. A payload beat appears on the XGMII outputs two clock edges after it is accepted. The start word takes the output slot one edge after the start beat is accepted. The ready signal is withdrawn after every end-of-packet beat so that the tail and the next frame's start word have output slots of their own. It is withdrawn for one more cycle when the tail does not fit into the last word.

Byte lane k of a bus is bits [8k+7:8k], and lane 0 carries the earliest byte in frame order. A control flag of 1 on lane k marks that lane as a control character.

Top module: `xgmii_tx_mac`

## Requirements
- R1: During reset, and on the cycle after any clock edge with reset (rst_n) low, every output lane carries idle 0x07 with its control flag set, and in_ready is high.
- R2: One clock edge after a start-of-packet beat is accepted, the output word has 0xFB in lane 0 with its control flag set, 0x55 in lanes 1 to 6 and 0xD5 in lane 7, with those seven flags clear (control flags = 0x01).
- R3: The check sequence is CRC-32 with polynomial 0x04C11DB7 in bit-reflected form, preset to all ones, with the result inverted. It is sent least significant byte first. For the nine payload bytes "123456789" the value is 0xCBF43926, so the bytes on the wire are 0x26, 0x39, 0xF4, 0xCB.
- R4: Each accepted beat that is not an end-of-packet beat appears unchanged on the output, with all control flags clear, two clock edges after it is accepted. Beats of one frame occupy consecutive output words.
- R5: On an end-of-packet beat, the valid byte count is n = 8 − in_empty, where in_empty ranges from 0 to 7. The output word carries those n bytes in lanes 0 to n−1, followed by the CRC bytes, then 0xFD with its control flag set, then idle in any lanes that are left.
- R6: When n is 4 or more, the tail does not fit in one word. The next output word carries the CRC bytes that remain, then 0xFD, then idle, all in lane order.
- R7: After an end-of-packet beat is accepted, in_ready is low for exactly one cycle when n ≤ 3 and for exactly two cycles when n ≥ 4. It is high again after that.
- R8: When no frame is in flight, every output lane carries idle with its control flag set.
- R9: The bytes in the unused lanes of an end-of-packet beat have no effect on any output word.
- R10: Frames sent back to back, with in_valid held high throughout, come out complete and correct, each with its own start word and its own tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the stream side and the XGMII side |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 64 | Stream beat, lane 0 is the earliest byte |
| in_valid | input | 1 | The beat on in_data is valid |
| in_ready | output | 1 | The block takes the beat at the next edge |
| in_sop | input | 1 | The beat is the first of a frame |
| in_eop | input | 1 | The beat is the last of a frame |
| in_empty | input | 3 | Unused upper lanes on the last beat |
| xgmii_txd | output | 64 | XGMII transmit data, eight byte lanes |
| xgmii_txc | output | 8 | XGMII per-lane control flags |

## Verification
The bench builds the block with its default eight lanes, which is the only width an XGMII port uses. At that width, frames of 1 to 17 bytes cover every end-byte count from one to eight. They include single-beat frames, tails that fit in the last word and tails that spill into an extra word. With eight lanes the split between one and two ready-low cycles falls at n = 4. A back-to-back run with one spilling tail and one fitting tail measures both stall lengths directly on in_ready.

// File: rtl/xtx_pkg.sv
// Package for the XGMII transmit MAC: character codes, the CRC polynomial
// and a byte-wide CRC-32 step shared by the engine.
package xtx_pkg;

    localparam logic [7:0]  CH_IDLE   = 8'h07;
    localparam logic [7:0]  CH_START  = 8'hFB;
    localparam logic [7:0]  CH_TERM   = 8'hFD;
    localparam logic [7:0]  CH_PREAM  = 8'h55;
    localparam logic [7:0]  CH_SFD    = 8'hD5;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
    localparam int          CRC_BYTES     = 4;
    localparam int          TAIL_BYTES    = CRC_BYTES + 1;

    // Advance a reflected CRC-32 register by one byte, LSB first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h000000, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/xtx_crc_engine.sv
// Parallel CRC-32 update over one beat. Lanes at or beyond nbytes are
// skipped, so any count from 1 to LANES folds in correctly.
// Assumes: lane 0 holds the earliest byte; crc_in is the running register.
module xtx_crc_engine #(
    parameter int LANES = 8,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [31:0]          crc_in,
    input  logic [8*LANES-1:0]   data,
    input  logic [CNT_W-1:0]     nbytes,
    output logic [31:0]          crc_out
);
    import xtx_pkg::*;

    logic [31:0] chain [LANES+1];

    assign chain[0] = crc_in;

    // One CRC byte stage per lane, bypassed past the end of the frame.
    for (genvar g = 0; g < LANES; g++) begin : g_stage
        assign chain[g+1] = (CNT_W'(g) < nbytes) ? crc32_byte(chain[g], data[8*g +: 8])
                                                 : chain[g];
    end

    assign crc_out = chain[LANES];

endmodule

// File: rtl/xtx_tail_builder.sv
// Lays out the closing words of a frame: n payload bytes, four CRC bytes
// (LSB first), the terminate character, then idle. The layout spans two
// words; spill flags when the second word is needed.
// Assumes: 1 <= nbytes <= LANES; crc_fin is already inverted.
module xtx_tail_builder #(
    parameter int LANES = 8,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [8*LANES-1:0]   data,
    input  logic [CNT_W-1:0]     nbytes,
    input  logic [31:0]          crc_fin,
    output logic [8*LANES-1:0]   w0_d,
    output logic [LANES-1:0]     w0_c,
    output logic [8*LANES-1:0]   w1_d,
    output logic [LANES-1:0]     w1_c,
    output logic                 spill
);
    import xtx_pkg::*;

    assign spill = (int'(nbytes) + TAIL_BYTES) > LANES;

    for (genvar j = 0; j < 2*LANES; j++) begin : g_lane
        localparam int J = j;
        logic [7:0] pay;
        logic [7:0] b;
        logic       c;

        if (j < LANES) begin : g_pay
            assign pay = data[8*j +: 8];
        end else begin : g_nopay
            assign pay = 8'h00;
        end

        // Pick payload, CRC, terminate or idle for this tail position.
        always_comb begin
            int          n;
            logic [31:0] crc_sh;
            n      = int'(nbytes);
            crc_sh = 32'h0;
            b      = CH_IDLE;
            c      = 1'b1;
            if (J < n) begin
                b = pay;
                c = 1'b0;
            end else if (J < n + CRC_BYTES) begin
                crc_sh = crc_fin >> (8 * (J - n));
                b      = crc_sh[7:0];
                c      = 1'b0;
            end else if (J == n + CRC_BYTES) begin
                b = CH_TERM;
                c = 1'b1;
            end
        end

        if (j < LANES) begin : g_w0
            assign w0_d[8*j +: 8] = b;
            assign w0_c[j]        = c;
        end else begin : g_w1
            assign w1_d[8*(j-LANES) +: 8] = b;
            assign w1_c[j-LANES]          = c;
        end
    end

endmodule

// File: rtl/xtx_ingress.sv
// Stream-side stage: accepts beats, holds one beat for the output stage,
// and keeps the running CRC over everything accepted so far.
// Assumes: frames are well formed and arrive without gaps between beats.
module xtx_ingress #(
    parameter int LANES = 8,
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int EMP_W = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [8*LANES-1:0]   in_data,
    input  logic                 in_valid,
    input  logic                 in_sop,
    input  logic                 in_eop,
    input  logic [EMP_W-1:0]     in_empty,
    input  logic                 spill_pend,
    output logic                 in_ready,
    output logic                 accept,
    output logic                 s1_valid,
    output logic                 s1_eop,
    output logic [8*LANES-1:0]   s1_data,
    output logic [CNT_W-1:0]     s1_nbytes,
    output logic [31:0]          crc_run
);
    import xtx_pkg::*;

    logic [CNT_W-1:0] nb_in;
    logic [31:0]      crc_seed;
    logic [31:0]      crc_next;

    // Hold off while a tail word or spill word still owns the next slot.
    assign in_ready = !(s1_valid && s1_eop) && !spill_pend;
    assign accept   = in_valid && in_ready;

    // Byte count of the incoming beat.
    assign nb_in    = in_eop ? (CNT_W'(LANES) - CNT_W'(in_empty)) : CNT_W'(LANES);
    assign crc_seed = in_sop ? CRC_PRESET : crc_run;

    xtx_crc_engine #(.LANES(LANES)) u_crc (
        .crc_in  (crc_seed),
        .data    (in_data),
        .nbytes  (nb_in),
        .crc_out (crc_next)
    );

    // Capture the accepted beat and fold it into the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_eop    <= 1'b0;
            s1_data   <= '0;
            s1_nbytes <= '0;
            crc_run   <= CRC_PRESET;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_eop    <= in_eop;
                s1_data   <= in_data;
                s1_nbytes <= nb_in;
                crc_run   <= crc_next;
            end
        end
    end

endmodule

// File: rtl/xgmii_tx_mac.sv
// XGMII transmit MAC top. It picks each output word from the spill word,
// a start word, the held beat or its tail, or idle, and registers it.
// Assumes: one clock for both sides; the source does not stall inside a frame.
module xgmii_tx_mac #(
    parameter int LANES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [8*LANES-1:0]         in_data,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic                       in_sop,
    input  logic                       in_eop,
    input  logic [$clog2(LANES)-1:0]   in_empty,
    output logic [8*LANES-1:0]         xgmii_txd,
    output logic [LANES-1:0]           xgmii_txc
);
    import xtx_pkg::*;

    localparam int CNT_W = $clog2(LANES + 1);

    logic                 accept;
    logic                 s1_valid;
    logic                 s1_eop;
    logic [8*LANES-1:0]   s1_data;
    logic [CNT_W-1:0]     s1_nbytes;
    logic [31:0]          crc_run;
    logic                 spill_pend;
    logic [8*LANES-1:0]   spill_d;
    logic [LANES-1:0]     spill_c;
    logic [8*LANES-1:0]   w0_d, w1_d;
    logic [LANES-1:0]     w0_c, w1_c;
    logic                 tail_spill;
    logic [8*LANES-1:0]   pre_d;
    logic [8*LANES-1:0]   idle_d;
    logic                 start_now;

    xtx_ingress #(.LANES(LANES)) u_ing (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_empty   (in_empty),
        .spill_pend (spill_pend),
        .in_ready   (in_ready),
        .accept     (accept),
        .s1_valid   (s1_valid),
        .s1_eop     (s1_eop),
        .s1_data    (s1_data),
        .s1_nbytes  (s1_nbytes),
        .crc_run    (crc_run)
    );

    xtx_tail_builder #(.LANES(LANES)) u_tail (
        .data    (s1_data),
        .nbytes  (s1_nbytes),
        .crc_fin (~crc_run),
        .w0_d    (w0_d),
        .w0_c    (w0_c),
        .w1_d    (w1_d),
        .w1_c    (w1_c),
        .spill   (tail_spill)
    );

    // Start word: start character, preamble, delimiter in the top lane.
    for (genvar j = 0; j < LANES; j++) begin : g_pre
        if (j == 0) begin : g_st
            assign pre_d[8*j +: 8] = CH_START;
        end else if (j == LANES - 1) begin : g_sfd
            assign pre_d[8*j +: 8] = CH_SFD;
        end else begin : g_pa
            assign pre_d[8*j +: 8] = CH_PREAM;
        end
        assign idle_d[8*j +: 8] = CH_IDLE;
    end

    assign start_now = accept && in_sop;

    // Select and register the next XGMII word; remember any spill word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xgmii_txd  <= idle_d;
            xgmii_txc  <= '1;
            spill_pend <= 1'b0;
            spill_d    <= idle_d;
            spill_c    <= '1;
        end else begin
            spill_pend <= 1'b0;
            if (spill_pend) begin
                xgmii_txd <= spill_d;
                xgmii_txc <= spill_c;
            end else if (start_now) begin
                xgmii_txd <= pre_d;
                xgmii_txc <= LANES'(1);
            end else if (s1_valid && s1_eop) begin
                xgmii_txd <= w0_d;
                xgmii_txc <= w0_c;
                if (tail_spill) begin
                    spill_pend <= 1'b1;
                    spill_d    <= w1_d;
                    spill_c    <= w1_c;
                end
            end else if (s1_valid) begin
                xgmii_txd <= s1_data;
                xgmii_txc <= '0;
            end else begin
                xgmii_txd <= idle_d;
                xgmii_txc <= '1;
            end
        end
    end

    // R2
    start_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sop) |=> (xgmii_txc == LANES'(1) && xgmii_txd[7:0] == CH_START));

    // R7
    eop_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eop) |=> !in_ready);

    // R6
    spill_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_eop && tail_spill) |=> (spill_pend && !in_ready));

    // R7
    spill_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spill_pend |=> (in_ready && !spill_pend));

    // R8
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_valid && !spill_pend && !(in_valid && in_ready && in_sop)) |=> (xgmii_txc == '1));

endmodule

// File: tb/sim_xgmii_tx_mac.sv
module sim_xgmii_tx_mac;

    localparam int CAPN = 4096;
    localparam int WD   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] in_data;
    logic        in_valid;
    logic        in_ready;
    logic        in_sop;
    logic        in_eop;
    logic [2:0]  in_empty;
    logic [63:0] xgmii_txd;
    logic [7:0]  xgmii_txc;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [63:0] cap_d [CAPN];
    logic [7:0]  cap_c [CAPN];
    logic [7:0]  pool  [512];

    localparam logic [71:0] IDLE_W = {8'hFF, 64'h0707070707070707};
    localparam logic [71:0] PRE_W  = {8'h01, 64'hD5555555555555FB};

    xgmii_tx_mac u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_empty  (in_empty),
        .xgmii_txd (xgmii_txd),
        .xgmii_txc (xgmii_txc)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < CAPN) begin
            cap_d[cyc] = xgmii_txd;
            cap_c[cyc] = xgmii_txc;
        end
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == WD) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual cycle %0d expected below %0d", cyc, WD);
            report();
        end
    end

    task automatic chk(input string req, input string note, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, note, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int base, input int len);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < len; k++) begin
            c = c ^ {24'h0, pool[base + k]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic fill(input int base, input int len, input int seed);
        for (int k = 0; k < len; k++) pool[base + k] = 8'(seed * 31 + k * 7 + 3);
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        in_data  = '0;
        in_empty = '0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Drive one frame; acc is the output index of its start word.
    task automatic send(input int base, input int len, input bit junk, output int acc, output int stalls);
        int nb;
        nb     = (len + 7) / 8;
        stalls = 0;
        acc    = 0;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            for (int l = 0; l < 8; l++) begin
                int k;
                k = 8 * i + l;
                in_data[8*l +: 8] = (k < len) ? pool[base + k] : (junk ? 8'(8'hA5 ^ l) : 8'h00);
            end
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == nb - 1);
            in_empty = (i == nb - 1) ? 3'(8 * nb - len) : 3'd0;
            while (!in_ready) begin
                if (i == 0) stalls++;
                @(negedge clk);
            end
            if (i == 0) acc = cyc + 1;
        end
    endtask

    task automatic expect_frame(input int base, input int len, input int acc, input bit idle_after, input string note);
        logic [31:0] crc;
        int          nwords;
        crc    = ref_crc(base, len);
        nwords = (len + 5 + 7) / 8;
        chk("R2", note, {cap_c[acc], cap_d[acc]}, PRE_W);
        for (int w = 0; w < nwords; w++) begin
            logic [63:0] ed;
            logic [7:0]  ec;
            logic [31:0] sh;
            string       tag;
            for (int l = 0; l < 8; l++) begin
                int k;
                k = 8 * w + l;
                if (k < len) begin
                    ed[8*l +: 8] = pool[base + k]; ec[l] = 1'b0;
                end else if (k < len + 4) begin
                    sh = crc >> (8 * (k - len));
                    ed[8*l +: 8] = sh[7:0]; ec[l] = 1'b0;
                end else if (k == len + 4) begin
                    ed[8*l +: 8] = 8'hFD; ec[l] = 1'b1;
                end else begin
                    ed[8*l +: 8] = 8'h07; ec[l] = 1'b1;
                end
            end
            if (8 * w >= len)            tag = "R6";
            else if (8 * (w + 1) > len)  tag = "R5";
            else                         tag = "R4";
            chk(tag, note, {cap_c[acc + 1 + w], cap_d[acc + 1 + w]}, {ec, ed});
        end
        if (idle_after) chk("R8", note, {cap_c[acc + 1 + nwords], cap_d[acc + 1 + nwords]}, IDLE_W);
    endtask

    // R1: reset state, checked while reset is held.
    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0; in_empty = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset word", {xgmii_txc, xgmii_txd}, IDLE_W);
        chk("R1", "reset ready", {71'h0, in_ready}, 72'h1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R3: known check value over "123456789".
    task automatic t_known;
        int acc, st;
        for (int k = 0; k < 9; k++) pool[k] = 8'(8'h31 + k);
        send(0, 9, 1'b0, acc, st);
        go_idle(8);
        expect_frame(0, 9, acc, 1'b1, "known vector");
        chk("R3", "check value lanes", {cap_c[acc + 2], cap_d[acc + 2]}, {8'hE0, 64'h0707FDCBF4392639});
    endtask

    // R5 R6 R4: every frame length from 1 to 17 bytes.
    task automatic t_sweep;
        for (int len = 1; len <= 17; len++) begin
            int acc, st;
            fill(100, len, len);
            send(100, len, 1'b0, acc, st);
            go_idle(8);
            expect_frame(100, len, acc, 1'b1, $sformatf("sweep len %0d", len));
        end
    endtask

    // R9: junk in unused lanes of the last beat.
    task automatic t_junk;
        int acc, st;
        fill(200, 13, 77);
        send(200, 13, 1'b1, acc, st);
        go_idle(8);
        expect_frame(200, 13, acc, 1'b1, "R9 junk lanes");
        fill(200, 2, 78);
        send(200, 2, 1'b1, acc, st);
        go_idle(8);
        expect_frame(200, 2, acc, 1'b1, "R9 junk single beat");
    endtask

    // R10 R7: back-to-back frames with in_valid held high.
    task automatic t_b2b;
        int a0, a1, a2, s0, s1, s2;
        fill(300, 12, 5);
        fill(340, 10, 6);
        fill(380, 19, 7);
        send(300, 12, 1'b0, a0, s0);
        send(340, 10, 1'b0, a1, s1);
        send(380, 19, 1'b0, a2, s2);
        go_idle(10);
        chk("R7", "stall after n=4 tail", 72'(s1), 72'd2);
        chk("R7", "stall after n=2 tail", 72'(s2), 72'd1);
        expect_frame(300, 12, a0, 1'b0, "R10 frame A");
        expect_frame(340, 10, a1, 1'b0, "R10 frame B");
        expect_frame(380, 19, a2, 1'b1, "R10 frame C");
    endtask

    // R1: reset in the middle of a frame, then a clean frame.
    task automatic t_reset_mid;
        int acc, st;
        @(negedge clk);
        in_data = 64'h1122334455667788; in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_empty = '0;
        @(negedge clk);
        in_data = 64'h99AABBCCDDEEFF00; in_sop = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R1", "mid-frame reset word", {xgmii_txc, xgmii_txd}, IDLE_W);
        chk("R1", "mid-frame reset ready", {71'h0, in_ready}, 72'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "idle after reset", {xgmii_txc, xgmii_txd}, IDLE_W);
        fill(450, 6, 9);
        send(450, 6, 1'b0, acc, st);
        go_idle(8);
        expect_frame(450, 6, acc, 1'b1, "after reset");
    endtask

    initial begin
        t_reset();
        t_known();
        t_sweep();
        t_junk();
        t_b2b();
        t_reset_mid();
        report();
    end

endmodule